// File: doc/BRIEF.md
# Machine Status Word with Legal-Value Enforcement

This block holds the machine status word of a small processor core. Every write is passed through a set of write-any-read-legal rules before it is stored. Only a fixed set of interrupt-enable, previous-privilege, floating-point-state and memory-access fields accept data. Previous-privilege values that the core cannot return to are silently discarded. Any non-off floating-point state is stored as dirty, and the summary-dirty flag in the top bit is always derived from the stored state.

The same word can also be reached through a supervisor view. Reads through this view are masked, and writes through it replace only the supervisor-visible bits before the machine-level rules are applied. Two static inputs tell the block whether supervisor and user privilege levels exist. When a committed write changes any field that affects address translation, the block raises a one-cycle flush pulse for the translation cache.

Top module: `mstat_reg`

## Requirements
- R1: A machine-view write stores data only into SIE (bit 1), MIE (bit 3), SPIE (bit 5), MPIE (bit 7), SPP (bit 8), MPP (bits 12:11), FS (bits 14:13), MPRV (bit 17), SUM (bit 18) and MXR (bit 19). All other bits keep their previous value, and XS (bits 16:15) stays zero.
- R2: A written MPP value of 2 leaves MPP unchanged. So does a value of 1 when `s_present` is low, and a value of 0 when `u_present` is low. Values 3, 1 (with `s_present` high) and 0 (with `u_present` high) are stored.
- R3: After the merge, a non-zero FS value is stored as 3. FS never reads as 1 or 2.
- R4: Bit XLEN-1 (SD) reads 1 exactly when FS is 3 or XS is 3. Written data in that bit has no effect.
- R5: `tlb_flush` is high for the one cycle after the clock edge that commits a write changing the stored MXR, MPP, MPRV or SUM. It is low in every other cycle.
- R6: `s_rdata` equals the stored word ANDed with the supervisor mask. That mask covers bits 0, 1, 4, 5, 8, 13 to 16, 18, 19 and XLEN-1.
- R7: A write with `wr_sview` high replaces only the supervisor-mask bits, and then applies R1 to R4. As a result, MIE, MPIE, MPP and MPRV are left unchanged.
- R8: Reset (`rst_n` low, asynchronous) clears the word to zero. `m_rdata` shows the stored word combinationally, and a write becomes visible right after the next rising clock edge. With `wr_en` low, `wr_data` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Commit a write on this clock edge |
| wr_sview | input | 1 | 1: write through the supervisor view, 0: machine view |
| wr_data | input | XLEN | Write data |
| s_present | input | 1 | Supervisor privilege level exists |
| u_present | input | 1 | User privilege level exists |
| m_rdata | output | XLEN | Machine view of the status word |
| s_rdata | output | XLEN | Supervisor view of the status word |
| tlb_flush | output | 1 | One-cycle translation flush pulse |

## Verification
Both read views are taken from the register with no further stage, so a write is checked in the cycle right after its committing edge, which is the first falling edge after that edge. The flush pulse is registered at that same edge and is sampled at that same falling edge. It is sampled again one cycle later, when it must already be low. Inputs change only on falling edges, so each sample sees settled state. The expected word and flush are predicted by a field-by-field model in the bench, from the value it last predicted.

// File: rtl/mstat_pkg.sv
package mstat_pkg;
  // Field positions of the status word (fixed by the decoding in the core)
  localparam int P_UIE    = 0;
  localparam int P_SIE    = 1;
  localparam int P_MIE    = 3;
  localparam int P_UPIE   = 4;
  localparam int P_SPIE   = 5;
  localparam int P_MPIE   = 7;
  localparam int P_SPP    = 8;
  localparam int P_MPP_LO = 11;
  localparam int P_FS_LO  = 13;
  localparam int P_XS_LO  = 15;
  localparam int P_MPRV   = 17;
  localparam int P_SUM    = 18;
  localparam int P_MXR    = 19;

  typedef enum logic [1:0] {
    LVL_USER  = 2'd0,
    LVL_SUPER = 2'd1,
    LVL_RSVD  = 2'd2,
    LVL_MACH  = 2'd3
  } priv_lvl_e;

  typedef enum logic [1:0] {
    EXT_OFF   = 2'd0,
    EXT_INIT  = 2'd1,
    EXT_CLEAN = 2'd2,
    EXT_DIRTY = 2'd3
  } ext_state_e;

  // Is a requested previous-privilege level one the core can return to
  function automatic logic mpp_legal(input logic [1:0] lvl, input logic s_ok, input logic u_ok);
    case (priv_lvl_e'(lvl))
      LVL_MACH:  return 1'b1;
      LVL_SUPER: return s_ok;
      LVL_USER:  return u_ok;
      default:   return 1'b0;
    endcase
  endfunction

  // Floating-point state squashed to off or dirty
  function automatic logic [1:0] fs_squash(input logic [1:0] fs);
    return (fs == EXT_OFF) ? EXT_OFF : EXT_DIRTY;
  endfunction
endpackage

// File: rtl/mstat_masks.sv
module mstat_masks #(
  parameter int XLEN = 32
) (
  output logic [XLEN-1:0] m_wmask,
  output logic [XLEN-1:0] s_vmask,
  output logic [XLEN-1:0] xlate_mask
);
  import mstat_pkg::*;
  localparam int SD_POS = XLEN - 1;

  always_comb begin
    m_wmask = '0;
    m_wmask[P_SIE]  = 1'b1;
    m_wmask[P_MIE]  = 1'b1;
    m_wmask[P_SPIE] = 1'b1;
    m_wmask[P_MPIE] = 1'b1;
    m_wmask[P_SPP]  = 1'b1;
    m_wmask[P_MPP_LO +: 2] = 2'b11;
    m_wmask[P_FS_LO +: 2]  = 2'b11;
    m_wmask[P_MPRV] = 1'b1;
    m_wmask[P_SUM]  = 1'b1;
    m_wmask[P_MXR]  = 1'b1;
  end

  always_comb begin
    s_vmask = '0;
    s_vmask[P_UIE]  = 1'b1;
    s_vmask[P_SIE]  = 1'b1;
    s_vmask[P_UPIE] = 1'b1;
    s_vmask[P_SPIE] = 1'b1;
    s_vmask[P_SPP]  = 1'b1;
    s_vmask[P_FS_LO +: 2] = 2'b11;
    s_vmask[P_XS_LO +: 2] = 2'b11;
    s_vmask[P_SUM]  = 1'b1;
    s_vmask[P_MXR]  = 1'b1;
    s_vmask[SD_POS] = 1'b1;
  end

  always_comb begin
    xlate_mask = '0;
    xlate_mask[P_MPP_LO +: 2] = 2'b11;
    xlate_mask[P_MPRV] = 1'b1;
    xlate_mask[P_SUM]  = 1'b1;
    xlate_mask[P_MXR]  = 1'b1;
  end
endmodule

// File: rtl/mstat_legalize.sv
module mstat_legalize #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] cur,
  input  logic [XLEN-1:0] wdata,
  input  logic            sview,
  input  logic            s_present,
  input  logic            u_present,
  input  logic [XLEN-1:0] m_wmask,
  input  logic [XLEN-1:0] s_vmask,
  input  logic [XLEN-1:0] xlate_mask,
  output logic [XLEN-1:0] nxt,
  output logic            xlate_change,
  output logic            mpp_dropped
);
  import mstat_pkg::*;
  localparam int SD_POS = XLEN - 1;

  logic [XLEN-1:0] src;
  logic [XLEN-1:0] eff_mask;
  logic [XLEN-1:0] merged;

  // Supervisor path: splice only the visible bits into the current word
  assign src = sview ? ((cur & ~s_vmask) | (wdata & s_vmask)) : wdata;

  assign mpp_dropped = !mpp_legal(src[P_MPP_LO +: 2], s_present, u_present);

  always_comb begin
    eff_mask = m_wmask;
    if (mpp_dropped) eff_mask[P_MPP_LO +: 2] = 2'b00;
  end

  always_comb begin
    merged = (cur & ~eff_mask) | (src & eff_mask);
    merged[P_FS_LO +: 2] = fs_squash(merged[P_FS_LO +: 2]);
    merged[SD_POS] = (merged[P_FS_LO +: 2] == EXT_DIRTY) ||
                     (merged[P_XS_LO +: 2] == EXT_DIRTY);
    nxt = merged;
  end

  assign xlate_change = |((nxt ^ cur) & xlate_mask);
endmodule

// File: rtl/mstat_reg.sv
module mstat_reg #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_sview,
  input  logic [XLEN-1:0] wr_data,
  input  logic            s_present,
  input  logic            u_present,
  output logic [XLEN-1:0] m_rdata,
  output logic [XLEN-1:0] s_rdata,
  output logic            tlb_flush
);
  import mstat_pkg::*;
  localparam int SD_POS = XLEN - 1;

  logic [XLEN-1:0] st_q;
  logic [XLEN-1:0] st_nxt;
  logic [XLEN-1:0] m_wmask, s_vmask, xlate_mask;
  logic            xlate_change;
  logic            mpp_dropped;
  logic            flush_q;

  mstat_masks #(.XLEN(XLEN)) u_masks (
    .m_wmask    (m_wmask),
    .s_vmask    (s_vmask),
    .xlate_mask (xlate_mask)
  );

  mstat_legalize #(.XLEN(XLEN)) u_legal (
    .cur          (st_q),
    .wdata        (wr_data),
    .sview        (wr_sview),
    .s_present    (s_present),
    .u_present    (u_present),
    .m_wmask      (m_wmask),
    .s_vmask      (s_vmask),
    .xlate_mask   (xlate_mask),
    .nxt          (st_nxt),
    .xlate_change (xlate_change),
    .mpp_dropped  (mpp_dropped)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= '0;
      flush_q <= 1'b0;
    end else begin
      flush_q <= wr_en && xlate_change;
      if (wr_en) st_q <= st_nxt;
    end
  end

  assign m_rdata   = st_q;
  assign s_rdata   = st_q & s_vmask;
  assign tlb_flush = flush_q;

  AST_KEEP_UNWRITABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(st_q & ~m_wmask & ~({{(XLEN-1){1'b0}}, 1'b1} << SD_POS))); // R1
  AST_MPP_NOT_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    st_q[P_MPP_LO +: 2] != LVL_RSVD); // R2
  AST_MPP_DROP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mpp_dropped) |=> $stable(st_q[P_MPP_LO +: 2])); // R2
  AST_FS_TWO_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    st_q[P_FS_LO +: 2] == EXT_OFF || st_q[P_FS_LO +: 2] == EXT_DIRTY); // R3
  AST_SD_FOLLOWS_FS: assert property (@(posedge clk) disable iff (!rst_n)
    st_q[SD_POS] == (st_q[P_FS_LO +: 2] == EXT_DIRTY)); // R4
  AST_FLUSH_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_flush |-> $past(wr_en)); // R5
  AST_SVIEW_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rdata & ~s_vmask) == '0); // R6
  AST_SWRITE_KEEPS_M: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sview) |=> ($stable(st_q[P_MIE]) && $stable(st_q[P_MPIE]) &&
                             $stable(st_q[P_MPRV]) && $stable(st_q[P_MPP_LO +: 2]))); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(st_q)); // R8
endmodule

// File: tb/tb_mstat_reg.sv
module tb_mstat_reg;
  localparam int CLK_PERIOD = 10;
  localparam int XL = 32;

  typedef struct packed {
    logic          sv;
    logic          sp;
    logic          up;
    logic [XL-1:0] d;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF},
    '{1'b0, 1'b1, 1'b1, 32'h0000_0000},
    '{1'b0, 1'b1, 1'b1, 32'h0000_1000},
    '{1'b0, 1'b1, 1'b1, 32'h0000_0800},
    '{1'b0, 1'b0, 1'b1, 32'h0000_1800},
    '{1'b0, 1'b0, 1'b1, 32'h0000_0800},
    '{1'b0, 1'b1, 1'b0, 32'h0000_0000},
    '{1'b0, 1'b1, 1'b1, 32'h0000_4000},
    '{1'b0, 1'b1, 1'b1, 32'h0000_2000},
    '{1'b1, 1'b1, 1'b1, 32'hFFFF_FFFF},
    '{1'b0, 1'b1, 1'b1, 32'h0002_1888},
    '{1'b1, 1'b1, 1'b1, 32'h0000_0000},
    '{1'b1, 1'b1, 1'b1, 32'h0001_E001}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_sview = 1'b0, s_present = 1'b1, u_present = 1'b1;
  logic [XL-1:0] wr_data = '0;
  logic [XL-1:0] m_rdata, s_rdata;
  logic tlb_flush;

  int n_tests = 0;
  int n_fail = 0;
  logic done = 1'b0;
  logic [XL-1:0] exp_w = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mstat_reg #(.XLEN(XL)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sview(wr_sview),
    .wr_data(wr_data), .s_present(s_present), .u_present(u_present),
    .m_rdata(m_rdata), .s_rdata(s_rdata), .tlb_flush(tlb_flush)
  );

  // Field-by-field prediction of the stored word
  function automatic logic [XL-1:0] predict(input logic [XL-1:0] cur, input logic [XL-1:0] d,
                                            input logic sv, input logic sp, input logic up);
    logic [XL-1:0] n;
    logic [1:0] lvl;
    n = cur;
    n[1] = d[1]; n[5] = d[5]; n[8] = d[8]; n[18] = d[18]; n[19] = d[19];
    n[14:13] = (d[14:13] == 2'd0) ? 2'd0 : 2'd3;
    if (!sv) begin
      n[3] = d[3]; n[7] = d[7]; n[17] = d[17];
      lvl = d[12:11];
      if (lvl == 2'd3 || (lvl == 2'd1 && sp) || (lvl == 2'd0 && up)) n[12:11] = lvl;
    end
    n[31] = (n[14:13] == 2'd3);
    return n;
  endfunction

  function automatic logic [XL-1:0] sview_of(input logic [XL-1:0] w);
    logic [XL-1:0] r;
    r = '0;
    r[0] = w[0]; r[1] = w[1]; r[4] = w[4]; r[5] = w[5]; r[8] = w[8];
    r[16:13] = w[16:13]; r[18] = w[18]; r[19] = w[19]; r[31] = w[31];
    return r;
  endfunction

  function automatic logic xlate_diff(input logic [XL-1:0] a, input logic [XL-1:0] b);
    return (a[19] != b[19]) || (a[18] != b[18]) || (a[17] != b[17]) || (a[12:11] != b[12:11]);
  endfunction

  task automatic check(input string req, input logic [XL-1:0] act, input logic [XL-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one write at a falling edge, commit at the rising edge, check at the next falling edge
  task automatic do_write(input logic sv, input logic sp, input logic up, input logic [XL-1:0] d,
                          input string req);
    logic [XL-1:0] nxt;
    logic fl;
    @(negedge clk);
    check({req, " R5 flush idle"}, {31'd0, tlb_flush}, '0);
    nxt = predict(exp_w, d, sv, sp, up);
    fl = xlate_diff(exp_w, nxt);
    wr_en = 1'b1; wr_sview = sv; s_present = sp; u_present = up; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = ~d;
    exp_w = nxt;
    check({req, " machine view"}, m_rdata, exp_w);
    check({req, " R6 supervisor view"}, s_rdata, sview_of(exp_w));
    check({req, " R5 flush pulse"}, {31'd0, tlb_flush}, {31'd0, fl});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 reset machine view", m_rdata, '0);
    check("R8 reset supervisor view", s_rdata, '0);
    check("R8 reset flush", {31'd0, tlb_flush}, '0);
    rst_n = 1'b1;

    // Vector table: R1 R2 R3 R4 R7 via the prediction model
    for (int i = 0; i < NV; i++) begin
      do_write(VEC[i].sv, VEC[i].sp, VEC[i].up, VEC[i].d, $sformatf("R1/R2/R3/R4/R7 vec%0d", i));
    end

    // R2: reserved level written while supervisor mode exists
    do_write(1'b0, 1'b1, 1'b1, 32'h0000_1800, "R2 setup mpp=3");
    do_write(1'b0, 1'b1, 1'b1, 32'h0000_1000, "R2 rsvd level");
    check("R2 mpp kept at 3", {30'd0, m_rdata[12:11]}, 32'd3);

    // R7: supervisor write cannot touch MPP/MIE/MPIE/MPRV
    do_write(1'b0, 1'b1, 1'b1, 32'h0002_1888, "R7 setup");
    do_write(1'b1, 1'b1, 1'b1, 32'h0000_0000, "R7 sview clear");
    check("R7 machine-only bits kept", m_rdata & 32'h0002_1888, 32'h0002_1888);

    // R4: SD written alone has no effect
    do_write(1'b0, 1'b1, 1'b1, 32'h8000_0000, "R4 sd write");
    check("R4 sd low", {31'd0, m_rdata[31]}, '0);

    // R8: idle cycles with changing data leave the word alone
    @(negedge clk);
    wr_data = 32'hFFFF_FFFF;
    @(negedge clk);
    wr_data = 32'h0000_0000;
    @(negedge clk);
    check("R8 no write without enable", m_rdata, exp_w);
    check("R5 no flush without write", {31'd0, tlb_flush}, '0);

    // R5: repeated identical write gives no second pulse
    do_write(1'b0, 1'b1, 1'b1, 32'h000E_1800, "R5 first");
    do_write(1'b0, 1'b1, 1'b1, 32'h000E_1800, "R5 repeat");

    // R8: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8 async reset clears", m_rdata, '0);
    exp_w = '0;
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule